// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit register file and a data memory that is addressed by byte but organised in words. On a load it takes the word read from memory, the low address bits, the access size and a signedness flag. It returns the register value: the addressed byte or halfword moved down to the low end, then sign-extended or zero-extended to the full width. On a store it builds the memory write word and a per-lane byte-enable mask, so that only the addressed lanes change.

Lane numbering is big endian. Address offset 0 names the most significant byte of the memory word, and the highest offset names the least significant byte. Halfword and word accesses that break their alignment rule are flagged as misaligned, and no lane is written for them. Every output is registered, so a request presented in one cycle is answered after the next rising clock edge.

Top module: `be_mem_aligner`

## Requirements
- R1: All outputs are registered and show the request sampled at the previous rising clock edge. A synchronous active-high reset clears `ld_data`, `wr_data`, `byte_en` and `misalign` to zero.
- R2: A byte load at offset k (0..3) returns memory bits [31-8k : 24-8k]. Offset 0 gives bits 31:24 and offset 3 gives bits 7:0.
- R3: A halfword load at offset 0 returns memory bits 31:16, and at offset 2 it returns bits 15:0.
- R4: With `acc_signed`=1, byte and halfword loads copy the top bit of the fetched field into every higher bit of `ld_data`.
- R5: With `acc_signed`=0, byte and halfword loads fill every bit above the fetched field with zero.
- R6: `acc_size` encodes 2'b00 byte, 2'b01 halfword and 2'b10 word, and 2'b11 behaves as word. An aligned word load returns the memory word unchanged, whatever `acc_signed` is.
- R7: A byte store places the low 8 bits of `st_data` in all four lanes of `wr_data`. It sets exactly one enable bit, bit (3-k) for offset k, where `byte_en` bit 3 covers bits 31:24.
- R8: A halfword store places the low 16 bits of `st_data` in both halves of `wr_data`. The enable is 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R9: An aligned word store drives `wr_data` equal to `st_data` and `byte_en`=4'b1111.
- R10: A halfword access with offset bit 0 set, or a word access with a nonzero offset, raises `misalign` and drives `byte_en`=0 and `ld_data`=0. A byte access is never misaligned.
- R11: A load (`is_store`=0) always drives `byte_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_store | input | 1 | 1 for a store, 0 for a load |
| acc_size | input | 2 | Access size code |
| acc_signed | input | 1 | Sign-extend narrow loads when 1 |
| addr_lo | input | 2 | Byte offset inside the word |
| mem_rdata | input | 32 | Word read from memory |
| st_data | input | 32 | Source register value for stores |
| ld_data | output | 32 | Aligned, extended load result |
| wr_data | output | 32 | Memory write word |
| byte_en | output | 4 | Lane write enables, bit 3 covers bits 31:24 |
| misalign | output | 1 | Alignment violation flag |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, which gives a 32-bit word and a 2-bit offset. This size puts every lane offset, both halfword positions and every misaligned offset within reach of exhaustive directed loops. Memory patterns whose fields have their top bit both set and clear cover sign extension and zero extension at every position.

// File: rtl/be_align_pkg.sv
package be_align_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_align_check.sv
module be_align_check
  import be_align_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             bad
);
  always_comb begin
    unique case (size)
      ACC_BYTE: bad = 1'b0;
      ACC_HALF: bad = ofs[0];
      default:  bad = (ofs != '0);
    endcase
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_align_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              sgn,
  input  logic              bad,
  output logic [DATA_W-1:0] value
);
  logic [BYTE_W-1:0] lane [LANES];
  logic [BYTE_W-1:0] byte_v;
  logic [HALF_W-1:0] half_v;
  logic [OFS_W-1:0]  hi_idx, lo_idx;

  // Big-endian lanes: offset 0 is the most significant byte.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = word[DATA_W-1-k*BYTE_W -: BYTE_W];
  end

  assign hi_idx = {ofs[OFS_W-1:1], 1'b0};
  assign lo_idx = {ofs[OFS_W-1:1], 1'b1};
  assign byte_v = lane[ofs];
  assign half_v = {lane[hi_idx], lane[lo_idx]};

  always_comb begin
    unique case (size)
      ACC_BYTE: value = {{(DATA_W-BYTE_W){sgn & byte_v[BYTE_W-1]}}, byte_v};
      ACC_HALF: value = {{(DATA_W-HALF_W){sgn & half_v[HALF_W-1]}}, half_v};
      default:  value = word;
    endcase
    if (bad) value = '0;
  end
endmodule

// File: rtl/be_store_place.sv
module be_store_place
  import be_align_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  input  logic              store,
  input  logic              bad,
  output logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  ben
);
  always_comb begin
    unique case (size)
      ACC_BYTE: wdata = {LANES{src[BYTE_W-1:0]}};
      ACC_HALF: wdata = {(LANES/2){src[HALF_W-1:0]}};
      default:  wdata = src;
    endcase
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      logic [OFS_W-1:0] kk;
      logic hit;
      kk = OFS_W'(k);
      unique case (size)
        ACC_BYTE: hit = (kk == ofs);
        ACC_HALF: hit = (kk[OFS_W-1:1] == ofs[OFS_W-1:1]);
        default:  hit = 1'b1;
      endcase
      ben[LANES-1-k] = hit & store & ~bad;
    end
  end
endmodule

// File: rtl/be_mem_aligner.sv
module be_mem_aligner
  import be_align_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_store,
  input  logic [1:0]        acc_size,
  input  logic              acc_signed,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  byte_en,
  output logic              misalign
);
  acc_size_e         size;
  logic              bad;
  logic [DATA_W-1:0] ld_next, wr_next;
  logic [LANES-1:0]  ben_next;

  assign size = acc_size_e'(acc_size);

  be_align_check #(.LANES(LANES)) i_check (
    .size(size), .ofs(addr_lo), .bad(bad)
  );

  be_load_extract #(.BYTE_W(BYTE_W), .LANES(LANES)) i_load (
    .word(mem_rdata), .ofs(addr_lo), .size(size), .sgn(acc_signed),
    .bad(bad), .value(ld_next)
  );

  be_store_place #(.BYTE_W(BYTE_W), .LANES(LANES)) i_store (
    .src(st_data), .ofs(addr_lo), .size(size), .store(is_store),
    .bad(bad), .wdata(wr_next), .ben(ben_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_data  <= '0;
      wr_data  <= '0;
      byte_en  <= '0;
      misalign <= 1'b0;
    end else begin
      ld_data  <= ld_next;
      wr_data  <= wr_next;
      byte_en  <= ben_next;
      misalign <= bad;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (ld_data == '0 && wr_data == '0 && byte_en == '0 && !misalign)); // R1

  AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!is_store && acc_signed && acc_size == 2'b00))
    |-> ld_data[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){ld_data[BYTE_W-1]}}); // R4

  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!is_store && !acc_signed && acc_size == 2'b00))
    |-> ld_data[DATA_W-1:BYTE_W] == '0); // R5

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_store && acc_size == 2'b00)) |-> $onehot(byte_en)); // R7

  AST_MISALIGN_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (byte_en == '0 && ld_data == '0)); // R10

  AST_LOAD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!is_store)) |-> byte_en == '0); // R11
endmodule

// File: tb/test_be_mem_aligner.sv
`timescale 1ns/1ps
module test_be_mem_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_store = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic        acc_signed = 1'b0;
  logic [1:0]  addr_lo = 2'b00;
  logic [31:0] mem_rdata = '0;
  logic [31:0] st_data = '0;
  logic [31:0] ld_data, wr_data;
  logic [3:0]  byte_en;
  logic        misalign;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  be_mem_aligner i_be_mem_aligner (
    .clk(clk), .rst(rst), .is_store(is_store), .acc_size(acc_size),
    .acc_signed(acc_signed), .addr_lo(addr_lo), .mem_rdata(mem_rdata),
    .st_data(st_data), .ld_data(ld_data), .wr_data(wr_data),
    .byte_en(byte_en), .misalign(misalign)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic bit ref_bad(logic [1:0] sz, logic [1:0] ofs);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return ofs[0];
    return ofs != 2'b00;
  endfunction

  function automatic logic [31:0] ref_load(logic [1:0] sz, bit sg, logic [1:0] ofs, logic [31:0] m);
    logic [31:0] sh;
    if (ref_bad(sz, ofs)) return 32'h0;
    if (sz == 2'b00) begin
      sh = m >> (8 * (3 - ofs));
      return sg ? 32'(signed'(sh[7:0])) : {24'h0, sh[7:0]};
    end
    if (sz == 2'b01) begin
      sh = ofs[1] ? m : (m >> 16);
      return sg ? 32'(signed'(sh[15:0])) : {16'h0, sh[15:0]};
    end
    return m;
  endfunction

  function automatic logic [3:0] ref_ben(bit st, logic [1:0] sz, logic [1:0] ofs);
    if (!st || ref_bad(sz, ofs)) return 4'h0;
    if (sz == 2'b00) return 4'b1000 >> ofs;
    if (sz == 2'b01) return ofs[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  // Drive at a falling edge, sample at the falling edge after the capture edge.
  task automatic run(string tag, bit st, logic [1:0] sz, bit sg, logic [1:0] ofs,
                     logic [31:0] m, logic [31:0] s);
    logic [31:0] ew;
    @(negedge clk);
    is_store = st; acc_size = sz; acc_signed = sg; addr_lo = ofs;
    mem_rdata = m; st_data = s;
    @(negedge clk);
    if (!st) check({tag, " ld_data"}, ld_data, ref_load(sz, sg, ofs, m));
    if (st) begin
      ew = (sz == 2'b00) ? {4{s[7:0]}} : (sz == 2'b01) ? {2{s[15:0]}} : s;
      check({tag, " wr_data"}, wr_data, ew);
    end
    check({tag, " byte_en"}, {28'h0, byte_en}, {28'h0, ref_ben(st, sz, ofs)});
    check({tag, " misalign"}, {31'h0, misalign}, {31'h0, ref_bad(sz, ofs)});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset ld_data", ld_data, 32'h0);
    check("R1 reset wr_data", wr_data, 32'h0);
    check("R1 reset byte_en", {28'h0, byte_en}, 32'h0);
    check("R1 reset misalign", {31'h0, misalign}, 32'h0);
  endtask

  task automatic t_byte_loads();
    for (int o = 0; o < 4; o++) begin
      run("R2 R5 byte unsigned", 0, 2'b00, 0, 2'(o), 32'h8F7E_A1C3, 0);
      run("R2 R4 byte signed", 0, 2'b00, 1, 2'(o), 32'h8F7E_A1C3, 0);
      run("R4 byte signed pos", 0, 2'b00, 1, 2'(o), 32'h1234_5678, 0);
    end
  endtask

  task automatic t_half_loads();
    for (int o = 0; o < 4; o += 2) begin
      run("R3 R5 half unsigned", 0, 2'b01, 0, 2'(o), 32'hC0DE_9ABC, 0);
      run("R3 R4 half signed", 0, 2'b01, 1, 2'(o), 32'hC0DE_9ABC, 0);
      run("R3 R4 half signed pos", 0, 2'b01, 1, 2'(o), 32'h7001_0FFF, 0);
    end
  endtask

  task automatic t_word_loads();
    run("R6 word load", 0, 2'b10, 0, 2'd0, 32'hDEAD_BEEF, 0);
    run("R6 word load signed", 0, 2'b10, 1, 2'd0, 32'h8000_0001, 0);
    run("R6 size3 as word", 0, 2'b11, 1, 2'd0, 32'hF00D_CAFE, 0);
  endtask

  task automatic t_stores();
    for (int o = 0; o < 4; o++)
      run("R7 byte store", 1, 2'b00, 0, 2'(o), 0, 32'h1122_33A5);
    run("R8 half store off0", 1, 2'b01, 0, 2'd0, 0, 32'hAABB_C3D4);
    run("R8 half store off2", 1, 2'b01, 1, 2'd2, 0, 32'h0102_8EF0);
    run("R9 word store", 1, 2'b10, 0, 2'd0, 0, 32'h89AB_CDEF);
  endtask

  task automatic t_misaligned();
    run("R10 half load off1", 0, 2'b01, 1, 2'd1, 32'hFFFF_FFFF, 0);
    run("R10 half store off3", 1, 2'b01, 0, 2'd3, 0, 32'h5555_AAAA);
    for (int o = 1; o < 4; o++) begin
      run("R10 word load", 0, 2'b10, 0, 2'(o), 32'hFEDC_BA98, 0);
      run("R10 word store", 1, 2'b10, 0, 2'(o), 0, 32'h1357_9BDF);
    end
  endtask

  task automatic t_load_no_enable();
    run("R11 load byte", 0, 2'b00, 0, 2'd2, 32'h0BAD_F00D, 32'hFFFF_FFFF);
    run("R11 load word", 0, 2'b10, 0, 2'd0, 32'h0BAD_F00D, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_byte_loads();
    t_half_loads();
    t_word_loads();
    t_stores();
    t_misaligned();
    t_load_no_enable();
    // Reset again mid-run with a live request present.
    @(negedge clk) rst = 1'b1;
    is_store = 1'b1; acc_size = 2'b10; addr_lo = 2'd0; st_data = 32'hFFFF_FFFF;
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule